// File: doc/BRIEF.md
# Single-Cell Li-ion Protection Controller

This block sits between a set of analog comparators and the gate drivers of the charge and discharge switches of a single Li-ion cell. Each comparator result is taken as an already-synchronous digital level. A fault is declared only after its condition has held without a break for its own delay, counted in clock ticks. Each declared fault then holds its switch off until its own release condition appears. The overvoltage, undervoltage, charge-overcurrent and discharge-overcurrent faults also set sticky flags, which only the host clears. A short circuit sets the discharge-overcurrent flag.

The host sees one 8-bit protection register and writes it through a write strobe. That register holds the four sticky flags, read-only copies of the two gate outputs, and two enables that the host can use to force either switch off. An undervoltage puts the block into sleep, with both switches off. A low level on the power-switch pin wakes it. The wake forces both enables back to 1. A separate latch records any low on the power-switch pin until the host re-arms it.

Top module: `cell_guard`

## Requirements
- R1: With `cell_ov` high for OV_DLY consecutive clock edges, `chg_off` goes to 1 and `prot_reg[7]` goes to 1 at the OV_DLY-th edge, while `dis_off` is unaffected.
- R2: Once an overvoltage is declared, the charge block ends at the first edge with `cell_below_ce` high. While `dis_cur_on` is high the overvoltage term does not hold `chg_off` high.
- R3: With `cell_uv` high for UV_DLY consecutive edges, the block enters sleep at the UV_DLY-th edge: `sleep_o`=1 and `prot_reg[6]`=1. While asleep, both `chg_off` and `dis_off` are 1.
- R4: With `chg_oc` high for OC_DLY consecutive edges, `chg_off`, `dis_off`, `pull_down_en` and `prot_reg[5]` become 1. Both switches stay off until the first edge with `pack_below` high, at which point `pull_down_en` returns to 0.
- R5: With `dis_oc` high for OC_DLY consecutive edges, `dis_off`, `pull_up_en` and `prot_reg[4]` become 1 and `chg_off` is unaffected. Discharge stays off until the first edge with `pack_above` high.
- R6: With `short_ckt` high for SC_DLY consecutive edges, `dis_off` becomes 1 and `prot_reg[4]` is set. The release is the same as in R5.
- R7: If a fault condition drops for even one edge before its delay expires, its count restarts from zero and no fault is declared.
- R8: `dis_off` = sleep | charge-overcurrent | discharge-overcurrent or short | DE==0. `chg_off` = (overvoltage & !`dis_cur_on`) | sleep | charge-overcurrent | CE==0. CE is `prot_reg[1]` and DE is `prot_reg[0]`, and a protection-register write loads both from `host_wdata[1:0]`.
- R9: Flags at bits 7..4 are sticky. A protection write with a 0 in a flag's bit clears that flag, and a 1 leaves it unchanged. A fault declared in the same edge as a clearing write leaves the flag set.
- R10: In sleep, a low on `ps_pin_n` returns the block to active at the next edge, with `prot_reg[1:0]`=2'b11, and a wake overrides a simultaneous host write. In active mode `ps_pin_n` has no effect on the gate outputs.
- R11: `ps_latch` resets to 1. It becomes 0 on any edge where `ps_pin_n` is low. It returns to 1 only on a `host_ps_set` pulse while the pin is high, because a low pin wins over the set.
- R12: `prot_reg` bit 3 mirrors `chg_off` and bit 2 mirrors `dis_off`. Writes to those two bits have no effect.
- R13: After reset, `prot_reg`=8'h03, both gate outputs are 0 (switches on), `sleep_o`=0, both test-current enables are 0 and `ps_latch`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_ov | input | 1 | Cell above overvoltage threshold |
| cell_below_ce | input | 1 | Cell below charge-enable threshold |
| cell_uv | input | 1 | Cell below undervoltage threshold |
| chg_oc | input | 1 | Charge-direction overcurrent comparator |
| dis_oc | input | 1 | Discharge-direction overcurrent comparator |
| short_ckt | input | 1 | Unfiltered short-circuit comparator |
| dis_cur_on | input | 1 | Discharge current above the small-current threshold |
| pack_above | input | 1 | Pack terminal above supply minus margin |
| pack_below | input | 1 | Pack terminal below supply minus margin |
| host_wr_prot | input | 1 | Protection register write strobe |
| host_wdata | input | 8 | Protection register write data |
| host_ps_set | input | 1 | Host writes 1 to the power-switch latch |
| ps_pin_n | input | 1 | Power-switch pin, active low |
| chg_off | output | 1 | Charge switch off (1 = off) |
| dis_off | output | 1 | Discharge switch off (1 = off) |
| pull_down_en | output | 1 | Enable pack-terminal pull-down test current |
| pull_up_en | output | 1 | Enable pack-terminal pull-up test current |
| sleep_o | output | 1 | Sleep mode indication |
| prot_reg | output | 8 | Protection register contents |
| ps_latch | output | 1 | Power-switch low-event latch |

## Verification
Two functions can land on the same edge and decide the same bit. The first pair is a fault qualifier reaching the end of its delay and a host write that clears that fault's flag. The second pair is a sleep-to-active wake and a host write to CE/DE. The bench provokes the first case by starting the write strobe exactly one cycle before the overvoltage count expires, so that both act on the same edge. It judges the result by requiring the flag to read 1 afterwards. It handles the wake/write pair and the power-switch low/re-arm pair the same way, requiring the forced value to win over the host write.

// File: rtl/cell_guard_pkg.sv
package cell_guard_pkg;

  typedef enum logic {
    MODE_ACTIVE = 1'b0,
    MODE_SLEEP  = 1'b1
  } mode_e;

  // Fault qualifier indices
  localparam int unsigned Q_OV  = 0;
  localparam int unsigned Q_UV  = 1;
  localparam int unsigned Q_COC = 2;
  localparam int unsigned Q_DOC = 3;
  localparam int unsigned Q_SC  = 4;
  localparam int unsigned NQUAL = 5;

  // Protection register bit positions (host decodes these)
  localparam int unsigned B_OV  = 7;
  localparam int unsigned B_UV  = 6;
  localparam int unsigned B_COC = 5;
  localparam int unsigned B_DOC = 4;
  localparam int unsigned B_CCM = 3;
  localparam int unsigned B_DCM = 2;
  localparam int unsigned B_CE  = 1;
  localparam int unsigned B_DE  = 0;
  localparam int unsigned REG_W = 8;

endpackage

// File: rtl/cg_qual.sv
module cg_qual #(
  parameter int unsigned DLY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic hit
);
  localparam int unsigned CW   = (DLY < 2) ? 1 : $clog2(DLY);
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    hit    = cond && (cnt_q == LAST);
    cnt_en = !cond || (cnt_q != LAST) || (cnt_q != '0);
    if (!cond)              cnt_d = '0;
    else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cg_mode.sv
module cg_mode
  import cell_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic uv_hit,
  input  logic ps_pin_n,
  output logic asleep,
  output logic wake
);
  mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    wake   = 1'b0;
    unique case (mode_q)
      MODE_ACTIVE: if (uv_hit) mode_d = MODE_SLEEP;
      MODE_SLEEP: begin
        if (!ps_pin_n) begin
          mode_d = MODE_ACTIVE;
          wake   = 1'b1;
        end
      end
      default: mode_d = MODE_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_ACTIVE;
    else        mode_q <= mode_d;
  end

  assign asleep = (mode_q == MODE_SLEEP);
endmodule

// File: rtl/cg_release.sv
module cg_release (
  input  logic clk,
  input  logic rst_n,
  input  logic ov_hit,
  input  logic coc_hit,
  input  logic doc_hit,
  input  logic below_ce,
  input  logic pack_below,
  input  logic pack_above,
  output logic ov_act,
  output logic coc_act,
  output logic doc_act
);
  logic ov_d, coc_d, doc_d;
  logic ov_en, coc_en, doc_en;

  always_comb begin
    ov_en  = ov_hit  || (ov_act  && below_ce);
    coc_en = coc_hit || (coc_act && pack_below);
    doc_en = doc_hit || (doc_act && pack_above);
    ov_d   = ov_hit;
    coc_d  = coc_hit;
    doc_d  = doc_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_act  <= 1'b0;
      coc_act <= 1'b0;
      doc_act <= 1'b0;
    end else begin
      if (ov_en)  ov_act  <= ov_d;
      if (coc_en) coc_act <= coc_d;
      if (doc_en) doc_act <= doc_d;
    end
  end
endmodule

// File: rtl/cg_flags.sv
module cg_flags
  import cell_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       set_vec,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             wake,
  output logic [3:0]       flags,
  output logic             ce,
  output logic             de
);
  logic [3:0] flags_d;
  logic [3:0] clr_vec;
  logic       en_en, ce_d, de_d;

  always_comb begin
    clr_vec = wr ? ~wdata[B_OV:B_DOC] : 4'b0000;
    flags_d = set_vec | (flags & ~clr_vec);
    en_en   = wake || wr;
    ce_d    = wake ? 1'b1 : wdata[B_CE];
    de_d    = wake ? 1'b1 : wdata[B_DE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= 4'b0000;
      ce    <= 1'b1;
      de    <= 1'b1;
    end else begin
      flags <= flags_d;
      if (en_en) begin
        ce <= ce_d;
        de <= de_d;
      end
    end
  end
endmodule

// File: rtl/cell_guard.sv
module cell_guard
  import cell_guard_pkg::*;
#(
  parameter int unsigned OV_DLY = 1000,
  parameter int unsigned UV_DLY = 1000,
  parameter int unsigned OC_DLY = 200,
  parameter int unsigned SC_DLY = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cell_ov,
  input  logic             cell_below_ce,
  input  logic             cell_uv,
  input  logic             chg_oc,
  input  logic             dis_oc,
  input  logic             short_ckt,
  input  logic             dis_cur_on,
  input  logic             pack_above,
  input  logic             pack_below,
  input  logic             host_wr_prot,
  input  logic [REG_W-1:0] host_wdata,
  input  logic             host_ps_set,
  input  logic             ps_pin_n,
  output logic             chg_off,
  output logic             dis_off,
  output logic             pull_down_en,
  output logic             pull_up_en,
  output logic             sleep_o,
  output logic [REG_W-1:0] prot_reg,
  output logic             ps_latch
);
  localparam int unsigned QDLY [NQUAL] = '{OV_DLY, UV_DLY, OC_DLY, OC_DLY, SC_DLY};

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // Fault qualification
  logic [NQUAL-1:0] qcond, qhit;

  always_comb begin
    qcond        = '0;
    qcond[Q_OV]  = cell_ov;
    qcond[Q_UV]  = cell_uv;
    qcond[Q_COC] = chg_oc;
    qcond[Q_DOC] = dis_oc;
    qcond[Q_SC]  = short_ckt;
  end

  for (genvar g = 0; g < NQUAL; g++) begin : g_qual
    cg_qual #(.DLY(QDLY[g])) u_qual (
      .clk  (clk),
      .rst_n(rst_q),
      .cond (qcond[g]),
      .hit  (qhit[g])
    );
  end

  logic doc_any;
  assign doc_any = qhit[Q_DOC] | qhit[Q_SC];

  // Operating mode
  logic asleep, wake;

  cg_mode u_mode (
    .clk     (clk),
    .rst_n   (rst_q),
    .uv_hit  (qhit[Q_UV]),
    .ps_pin_n(ps_pin_n),
    .asleep  (asleep),
    .wake    (wake)
  );

  // Fault hold and release
  logic ov_act, coc_act, doc_act;

  cg_release u_rel (
    .clk       (clk),
    .rst_n     (rst_q),
    .ov_hit    (qhit[Q_OV]),
    .coc_hit   (qhit[Q_COC]),
    .doc_hit   (doc_any),
    .below_ce  (cell_below_ce),
    .pack_below(pack_below),
    .pack_above(pack_above),
    .ov_act    (ov_act),
    .coc_act   (coc_act),
    .doc_act   (doc_act)
  );

  // Sticky flags and host enables
  logic [3:0] flags, set_vec;
  logic       ce, de;

  assign set_vec = {qhit[Q_OV], qhit[Q_UV], qhit[Q_COC], doc_any};

  cg_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_q),
    .set_vec(set_vec),
    .wr     (host_wr_prot),
    .wdata  (host_wdata),
    .wake   (wake),
    .flags  (flags),
    .ce     (ce),
    .de     (de)
  );

  // Power-switch event latch
  logic ps_d, ps_en;

  always_comb begin
    ps_en = !ps_pin_n || host_ps_set;
    ps_d  = ps_pin_n;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)     ps_latch <= 1'b1;
    else if (ps_en) ps_latch <= ps_d;
  end

  // Gate equations
  always_comb begin
    dis_off = asleep | coc_act | doc_act | !de;
    chg_off = (ov_act & !dis_cur_on) | asleep | coc_act | !ce;
  end

  assign pull_down_en = coc_act;
  assign pull_up_en   = doc_act;
  assign sleep_o      = asleep;

  always_comb begin
    prot_reg        = '0;
    prot_reg[B_OV]  = flags[3];
    prot_reg[B_UV]  = flags[2];
    prot_reg[B_COC] = flags[1];
    prot_reg[B_DOC] = flags[0];
    prot_reg[B_CCM] = chg_off;
    prot_reg[B_DCM] = dis_off;
    prot_reg[B_CE]  = ce;
    prot_reg[B_DE]  = de;
  end
endmodule

// File: rtl/cell_guard_chk.sv
module cell_guard_chk (
  input logic       clk,
  input logic       rst_q,
  input logic       host_wr_prot,
  input logic [7:0] host_wdata,
  input logic       ps_pin_n,
  input logic       chg_off,
  input logic       dis_off,
  input logic       pull_down_en,
  input logic       pull_up_en,
  input logic       sleep_o,
  input logic [7:0] prot_reg,
  input logic       ps_latch
);
  p_sleep_off_r3: assert property (@(posedge clk) disable iff (!rst_q)
    sleep_o |-> (chg_off && dis_off));

  p_pull_down_r4: assert property (@(posedge clk) disable iff (!rst_q)
    pull_down_en |-> (chg_off && dis_off));

  p_pull_up_r5: assert property (@(posedge clk) disable iff (!rst_q)
    pull_up_en |-> dis_off);

  p_ce_low_r8: assert property (@(posedge clk) disable iff (!rst_q)
    !prot_reg[1] |-> chg_off);

  p_de_low_r8: assert property (@(posedge clk) disable iff (!rst_q)
    !prot_reg[0] |-> dis_off);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (prot_reg[7] && !(host_wr_prot && !host_wdata[7])) |=> prot_reg[7]);

  p_wake_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (sleep_o && !ps_pin_n) |=> (!sleep_o && prot_reg[1:0] == 2'b11));

  p_ps_catch_r11: assert property (@(posedge clk) disable iff (!rst_q)
    !ps_pin_n |=> !ps_latch);
endmodule

bind cell_guard cell_guard_chk u_chk (
  .clk         (clk),
  .rst_q       (rst_q),
  .host_wr_prot(host_wr_prot),
  .host_wdata  (host_wdata),
  .ps_pin_n    (ps_pin_n),
  .chg_off     (chg_off),
  .dis_off     (dis_off),
  .pull_down_en(pull_down_en),
  .pull_up_en  (pull_up_en),
  .sleep_o     (sleep_o),
  .prot_reg    (prot_reg),
  .ps_latch    (ps_latch)
);

// File: tb/test_cell_guard.sv
`timescale 1ns/1ps
module test_cell_guard;
  localparam int OVD = 6;
  localparam int UVD = 8;
  localparam int OCD = 4;
  localparam int SCD = 2;
  // {ce, de, expected chg_off, expected dis_off}
  localparam logic [3:0] VEC [0:3] = '{4'b1100, 4'b1001, 4'b0110, 4'b0011};

  logic clk = 1'b0;
  logic rst_n;
  logic cell_ov, cell_below_ce, cell_uv, chg_oc, dis_oc, short_ckt;
  logic dis_cur_on, pack_above, pack_below;
  logic host_wr_prot, host_ps_set, ps_pin_n;
  logic [7:0] host_wdata;
  logic chg_off, dis_off, pull_down_en, pull_up_en, sleep_o, ps_latch;
  logic [7:0] prot_reg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cell_guard #(.OV_DLY(OVD), .UV_DLY(UVD), .OC_DLY(OCD), .SC_DLY(SCD)) i_cell_guard (
    .clk(clk), .rst_n(rst_n), .cell_ov(cell_ov), .cell_below_ce(cell_below_ce),
    .cell_uv(cell_uv), .chg_oc(chg_oc), .dis_oc(dis_oc), .short_ckt(short_ckt),
    .dis_cur_on(dis_cur_on), .pack_above(pack_above), .pack_below(pack_below),
    .host_wr_prot(host_wr_prot), .host_wdata(host_wdata), .host_ps_set(host_ps_set),
    .ps_pin_n(ps_pin_n), .chg_off(chg_off), .dis_off(dis_off),
    .pull_down_en(pull_down_en), .pull_up_en(pull_up_en), .sleep_o(sleep_o),
    .prot_reg(prot_reg), .ps_latch(ps_latch)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_prot(input logic [7:0] d);
    host_wdata   = d;
    host_wr_prot = 1'b1;
    tick(1);
    host_wr_prot = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL R13 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {cell_ov, cell_below_ce, cell_uv, chg_oc, dis_oc, short_ckt} = '0;
    {dis_cur_on, pack_above, pack_below, host_wr_prot, host_ps_set} = '0;
    ps_pin_n = 1'b1;
    host_wdata = 8'h00;
    tick(3);
    rst_n = 1'b1;
    tick(3);

    // R13 reset state
    chk("R13 prot_reg", prot_reg, 8'h03);
    chk("R13 gates", {6'b0, chg_off, dis_off}, 8'h00);
    chk("R13 misc", {4'b0, sleep_o, pull_down_en, pull_up_en, ps_latch}, 8'h01);

    // R8 enable table
    for (int i = 0; i < 4; i++) begin
      wr_prot({6'b0, VEC[i][3:2]});
      chk("R8 ce/de bits", {6'b0, prot_reg[1:0]}, {6'b0, VEC[i][3:2]});
      chk("R8 gates", {6'b0, chg_off, dis_off}, {6'b0, VEC[i][1:0]});
    end
    wr_prot(8'h03);

    // R7 interrupted overvoltage
    cell_ov = 1'b1; tick(OVD - 1);
    cell_ov = 1'b0; tick(1);
    cell_ov = 1'b1; tick(OVD - 1);
    chk("R7 no fault", {chg_off, prot_reg[7]}, 8'h00);
    cell_ov = 1'b0; tick(1);

    // R1 overvoltage qualification
    cell_ov = 1'b1; tick(OVD - 1);
    chk("R1 before delay", {7'b0, chg_off}, 8'h00);
    tick(1);
    chk("R1 after delay", {chg_off, dis_off, prot_reg[7]}, 8'h05);
    cell_ov = 1'b0; tick(2);
    chk("R2 held until below ce", {7'b0, chg_off}, 8'h01);
    dis_cur_on = 1'b1; tick(1);
    chk("R2 discharge current masks", {7'b0, chg_off}, 8'h00);
    dis_cur_on = 1'b0; tick(1);
    chk("R2 mask removed", {7'b0, chg_off}, 8'h01);
    cell_below_ce = 1'b1; tick(1);
    cell_below_ce = 1'b0; tick(1);
    chk("R2 released", {7'b0, chg_off}, 8'h00);

    // R9 / R12 flag writes
    wr_prot(8'hFF);
    chk("R9 write 1 keeps flag, R12 mirrors ignore writes", prot_reg, 8'h83);
    wr_prot(8'h7F);
    chk("R9 write 0 clears", prot_reg, 8'h03);

    // R9 clear in the same edge as qualification
    cell_ov = 1'b1; tick(OVD - 1);
    host_wdata = 8'h7F; host_wr_prot = 1'b1; tick(1);
    host_wr_prot = 1'b0;
    chk("R9 set wins over clear", {prot_reg[7], chg_off}, 8'h03);
    cell_ov = 1'b0;
    cell_below_ce = 1'b1; tick(1);
    cell_below_ce = 1'b0;
    wr_prot(8'h03);
    chk("R9 cleared afterwards", prot_reg, 8'h03);

    // R4 charge overcurrent
    chg_oc = 1'b1; tick(OCD - 1);
    chk("R4 before delay", {chg_off, dis_off, pull_down_en}, 8'h00);
    tick(1);
    chk("R4 tripped", {chg_off, dis_off, pull_down_en, prot_reg[5]}, 8'h0F);
    chg_oc = 1'b0; tick(2);
    chk("R4 held", {chg_off, dis_off, pull_down_en}, 8'h07);
    pack_below = 1'b1; tick(1);
    pack_below = 1'b0;
    chk("R4 released", {chg_off, dis_off, pull_down_en}, 8'h00);
    wr_prot(8'h03);

    // R5 discharge overcurrent
    dis_oc = 1'b1; tick(OCD);
    chk("R5 tripped", {chg_off, dis_off, pull_up_en, prot_reg[4]}, 8'h07);
    dis_oc = 1'b0; tick(2);
    chk("R5 held", {dis_off, pull_up_en}, 8'h03);
    pack_above = 1'b1; tick(1);
    pack_above = 1'b0;
    chk("R5 released", {dis_off, pull_up_en}, 8'h00);
    wr_prot(8'h03);

    // R6 short circuit
    short_ckt = 1'b1; tick(SCD - 1);
    chk("R6 before delay", {7'b0, dis_off}, 8'h00);
    tick(1);
    chk("R6 tripped", {chg_off, dis_off, prot_reg[4]}, 8'h03);
    short_ckt = 1'b0;
    pack_above = 1'b1; tick(1);
    pack_above = 1'b0;
    chk("R6 released", {7'b0, dis_off}, 8'h00);
    wr_prot(8'h03);

    // R10 / R11 power-switch pin while active
    wr_prot(8'h02);
    ps_pin_n = 1'b0; tick(1);
    ps_pin_n = 1'b1;
    chk("R10 pin ignored when active", {sleep_o, chg_off, dis_off}, 8'h01);
    chk("R11 latch caught low", {7'b0, ps_latch}, 8'h00);
    host_ps_set = 1'b1; tick(1);
    host_ps_set = 1'b0;
    chk("R11 re-armed", {7'b0, ps_latch}, 8'h01);
    ps_pin_n = 1'b0; host_ps_set = 1'b1; tick(1);
    ps_pin_n = 1'b1; host_ps_set = 1'b0;
    chk("R11 low wins over set", {7'b0, ps_latch}, 8'h00);
    host_ps_set = 1'b1; tick(1);
    host_ps_set = 1'b0;

    // R3 undervoltage sleep and R10 wake
    wr_prot(8'h00);
    cell_uv = 1'b1; tick(UVD - 1);
    chk("R3 before delay", {7'b0, sleep_o}, 8'h00);
    tick(1);
    chk("R3 asleep", {sleep_o, chg_off, dis_off, prot_reg[6]}, 8'h0F);
    cell_uv = 1'b0; tick(5);
    chk("R3 stays asleep", {7'b0, sleep_o}, 8'h01);
    ps_pin_n = 1'b0; host_wdata = 8'h40; host_wr_prot = 1'b1; tick(1);
    ps_pin_n = 1'b1; host_wr_prot = 1'b0;
    chk("R10 woke with enables forced", prot_reg, 8'h43);
    chk("R10 gates on", {sleep_o, chg_off, dis_off}, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule